// File: doc/BRIEF.md
# Deferred Arithmetic Result Commit Pipeline

This block takes the evaluation of an arithmetic result, and the write of that result into the register file, out of the clock in which the operation issues. In the issue clock the block only latches the two operands, the operation code and the absolute index of the destination register. The issuing instruction retires without touching the register file. A front evaluation stage then forms a wide raw result. A back stage scales, rounds and saturates that raw value, packs it to the register width, and presents it on a dedicated write port that is addressed by absolute index.

The `STAGES` parameter chooses the depth. With `STAGES = 1` the front and back stages are chained inside one clock, and the write happens one clock after issue. With `STAGES = 2` a register sits between the two stages, which splits the long evaluation cone in half, and the write happens two clocks after issue. Either way the result is in the register file before a dependent consumer is released, because the consumer is released three clocks after issue. A reader of a register that is still in flight would see the old value during this lag. The block therefore raises a hazard stall for any probe that matches a target held in any pipeline stage.

The arithmetic is a compact stand-in for a floating-point datapath. It has four operations: saturating add and subtract, a fixed-point multiply with `FRAC_W` fraction bits and round-half-up, and a saturating integer multiply. A new operation can be accepted in every clock.

Top module: `fp_defer_commit`

## Requirements
- R1: In the first clock after synchronous active-low reset is released, `wr_en` and `hz_stall` are both 0, provided no operation has been issued.
- R2: With `STAGES = 1`, an operation sampled with `iss_valid = 1` at clock edge N drives `wr_en = 1` and `wr_idx` = its target in the cycle that follows edge N. The write therefore lands at edge N+1.
- R3: With `STAGES = 2`, that write is presented in the cycle that follows edge N+1, and the register file takes it at edge N+2.
- R4: Operations issued in consecutive clocks are all committed, in issue order, with no operation lost and no back-pressure. The number of writes equals the number of issues.
- R5: `wr_en` is 1 only when the last stage holds a valid operation. A clock without an issue produces no write at the matching later cycle.
- R6: With `STAGES = 1`, `hz_stall` is 1 exactly when `rd_valid = 1` and `rd_idx` equals the target held in the stage-0 register.
- R7: With `STAGES = 2`, `hz_stall` is 1 exactly when `rd_valid = 1` and `rd_idx` matches a valid target in either stage 0 or stage 1.
- R8: Add and subtract are selected by `iss_op` 0 (a+b) and 1 (a-b). The operands are two's-complement `DATA_W`-bit values, and the result saturates to the signed `DATA_W` range.
- R9: `iss_op` 2 is a fixed-point multiply. The result is (a*b + 2^(FRAC_W-1)) shifted arithmetically right by `FRAC_W`, then saturated. `iss_op` 3 is a saturating integer a*b.
- R10: The value written for a given operation is identical for both depths, so the same input stream leaves the same final register contents.
- R11: Every commit lands no later than three clocks after its issue edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An operation issues this clock |
| iss_op | input | 2 | Operation code (0 add, 1 sub, 2 fixed multiply, 3 integer multiply) |
| iss_a | input | DATA_W | First operand, two's complement |
| iss_b | input | DATA_W | Second operand, two's complement |
| iss_tgt | input | IDX_W | Absolute destination register index |
| rd_valid | input | 1 | A register read probe is present |
| rd_idx | input | IDX_W | Register index the reader wants |
| hz_stall | output | 1 | The reader must wait one clock |
| wr_en | output | 1 | Register-file write enable |
| wr_idx | output | IDX_W | Absolute register index to write |
| wr_data | output | DATA_W | Packed result to write |

## Verification
A lost or stuck stage valid bit appears on the write port within one or two clocks of the affected issue. It shows up either as a missing `wr_en` or as a write that no issue produced. A corrupted target or carrier field appears as a wrong `wr_idx` or `wr_data` in the same cycle. That cycle is also when the register file would take the bad value. A stage left out of the hazard match shows up straight away as a missing `hz_stall` for a probe of the in-flight register. The reference model checks every port on every clock for both depths, so any of these faults is reported in the first cycle where it is visible.

// File: rtl/fpdc_pkg.sv
// Package: shared operation encoding for the deferred commit pipeline.
// Assumes a two-bit operation field driven by the issue logic.
package fpdc_pkg;

    localparam int FPDC_OP_W = 2;

    typedef enum logic [FPDC_OP_W-1:0] {
        FPDC_ADD  = 2'd0,
        FPDC_SUB  = 2'd1,
        FPDC_QMUL = 2'd2,
        FPDC_IMUL = 2'd3
    } fpdc_op_e;

endpackage

// File: rtl/fpdc_capture.sv
// Module: issue capture register (stage 0).
// Latches operands, operation and target when an operation issues.
// Assumes the issue logic does not retract iss_valid within a cycle.
module fpdc_capture
    import fpdc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iss_valid,
    input  logic [FPDC_OP_W-1:0]     iss_op,
    input  logic [DATA_W-1:0]        iss_a,
    input  logic [DATA_W-1:0]        iss_b,
    input  logic [IDX_W-1:0]         iss_tgt,
    output logic                     s0_v,
    output fpdc_op_e                 s0_op,
    output logic signed [DATA_W-1:0] s0_a,
    output logic signed [DATA_W-1:0] s0_b,
    output logic [IDX_W-1:0]         s0_tgt
);

    // Valid bit follows issue every clock, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_v <= 1'b0;
        end else begin
            s0_v <= iss_valid;
        end
    end

    // Payload loads only on issue, so idle clocks do not toggle it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_op  <= FPDC_ADD;
            s0_a   <= '0;
            s0_b   <= '0;
            s0_tgt <= '0;
        end else if (iss_valid) begin
            s0_op  <= fpdc_op_e'(iss_op);
            s0_a   <= iss_a;
            s0_b   <= iss_b;
            s0_tgt <= iss_tgt;
        end
    end

endmodule

// File: rtl/fpdc_front.sv
// Module: front evaluation stage (combinational).
// Forms the exact wide raw result and a flag that tells the back stage to
// apply the fixed-point scaling. RAW_W must hold a full signed product.
module fpdc_front
    import fpdc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RAW_W  = 2 * DATA_W + 1
) (
    input  fpdc_op_e                 op,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [RAW_W-1:0]  raw,
    output logic                     frac
);

    logic signed [RAW_W-1:0] a_w;
    logic signed [RAW_W-1:0] b_w;

    assign a_w = RAW_W'(a);
    assign b_w = RAW_W'(b);

    // Selects the unscaled arithmetic result for the operation.
    always_comb begin
        raw  = '0;
        frac = 1'b0;
        case (op)
            FPDC_ADD:  raw = a_w + b_w;
            FPDC_SUB:  raw = a_w - b_w;
            FPDC_QMUL: begin
                raw  = a_w * b_w;
                frac = 1'b1;
            end
            FPDC_IMUL: raw = a_w * b_w;
            default:   raw = '0;
        endcase
    end

endmodule

// File: rtl/fpdc_back.sv
// Module: back stage (combinational): round, saturate and pack.
// Fixed-point results get half an LSB added before the arithmetic shift,
// then every result is clamped to the signed DATA_W range.
module fpdc_back #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8,
    parameter int RAW_W  = 2 * DATA_W + 1
) (
    input  logic signed [RAW_W-1:0] raw,
    input  logic                    frac,
    output logic [DATA_W-1:0]       packed_res
);

    localparam logic signed [RAW_W-1:0] HALF   = RAW_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [RAW_W-1:0] SAT_HI =
        RAW_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [RAW_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [RAW_W-1:0] scaled;

    // Rounds and rescales the fixed-point products; others pass through.
    always_comb begin
        if (frac) begin
            scaled = (raw + HALF) >>> FRAC_W;
        end else begin
            scaled = raw;
        end
    end

    // Clamps to the representable range and packs to the register width.
    always_comb begin
        if (scaled > SAT_HI) begin
            packed_res = SAT_HI[DATA_W-1:0];
        end else if (scaled < SAT_LO) begin
            packed_res = SAT_LO[DATA_W-1:0];
        end else begin
            packed_res = scaled[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/fpdc_hazard.sv
// Module: read-after-write hazard detector.
// Compares a reader's index against the target of every valid in-flight
// stage. A match means the register file still holds the old value.
module fpdc_hazard #(
    parameter int IDX_W = 3,
    parameter int DEPTH = 2
) (
    input  logic                        rd_valid,
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic [DEPTH-1:0]            stage_v,
    input  logic [DEPTH-1:0][IDX_W-1:0] stage_t,
    output logic                        stall
);

    logic [DEPTH-1:0] hit;

    // One comparator per in-flight stage.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = stage_v[i] && (stage_t[i] == rd_idx);
    end

    assign stall = rd_valid && (|hit);

endmodule

// File: rtl/fp_defer_commit.sv
// Module: deferred arithmetic commit pipeline (top).
// Captures an issued operation, evaluates it in one or two later clocks
// (STAGES = 1 or 2) and writes the result through an absolute-index port.
// Assumes the consumer scoreboard releases dependents at issue + 3, and
// that other readers honour hz_stall. STAGES values other than 2 build
// the one-stage form.
module fp_defer_commit
    import fpdc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8,
    parameter int IDX_W  = 3,
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [FPDC_OP_W-1:0] iss_op,
    input  logic [DATA_W-1:0]    iss_a,
    input  logic [DATA_W-1:0]    iss_b,
    input  logic [IDX_W-1:0]     iss_tgt,
    input  logic                 rd_valid,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 hz_stall,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [DATA_W-1:0]    wr_data
);

    localparam int RAW_W = 2 * DATA_W + 1;
    localparam int DEPTH = (STAGES == 2) ? 2 : 1;

    logic                     s0_v;
    fpdc_op_e                 s0_op;
    logic signed [DATA_W-1:0] s0_a;
    logic signed [DATA_W-1:0] s0_b;
    logic [IDX_W-1:0]         s0_tgt;

    logic signed [RAW_W-1:0]  f_raw;
    logic                     f_frac;

    logic                     l_v;
    logic signed [RAW_W-1:0]  l_raw;
    logic                     l_frac;
    logic [IDX_W-1:0]         l_tgt;

    logic [DEPTH-1:0]            hz_v;
    logic [DEPTH-1:0][IDX_W-1:0] hz_t;

    fpdc_capture #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_op    (iss_op),
        .iss_a     (iss_a),
        .iss_b     (iss_b),
        .iss_tgt   (iss_tgt),
        .s0_v      (s0_v),
        .s0_op     (s0_op),
        .s0_a      (s0_a),
        .s0_b      (s0_b),
        .s0_tgt    (s0_tgt)
    );

    fpdc_front #(
        .DATA_W (DATA_W),
        .RAW_W  (RAW_W)
    ) u_front (
        .op   (s0_op),
        .a    (s0_a),
        .b    (s0_b),
        .raw  (f_raw),
        .frac (f_frac)
    );

    if (STAGES == 2) begin : g_two
        logic                    s1_v;
        logic signed [RAW_W-1:0] s1_raw;
        logic                    s1_frac;
        logic [IDX_W-1:0]        s1_tgt;

        // Stage-1 valid bit tracks stage 0 each clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_v <= 1'b0;
            end else begin
                s1_v <= s0_v;
            end
        end

        // Carrier register at the front/back cut, loaded only when valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_raw  <= '0;
                s1_frac <= 1'b0;
                s1_tgt  <= '0;
            end else if (s0_v) begin
                s1_raw  <= f_raw;
                s1_frac <= f_frac;
                s1_tgt  <= s0_tgt;
            end
        end

        assign l_v    = s1_v;
        assign l_raw  = s1_raw;
        assign l_frac = s1_frac;
        assign l_tgt  = s1_tgt;
        assign hz_v   = {s1_v, s0_v};
        assign hz_t   = {s1_tgt, s0_tgt};
    end else begin : g_one
        assign l_v    = s0_v;
        assign l_raw  = f_raw;
        assign l_frac = f_frac;
        assign l_tgt  = s0_tgt;
        assign hz_v   = s0_v;
        assign hz_t   = s0_tgt;
    end

    fpdc_back #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .RAW_W  (RAW_W)
    ) u_back (
        .raw        (l_raw),
        .frac       (l_frac),
        .packed_res (wr_data)
    );

    fpdc_hazard #(
        .IDX_W (IDX_W),
        .DEPTH (DEPTH)
    ) u_hazard (
        .rd_valid (rd_valid),
        .rd_idx   (rd_idx),
        .stage_v  (hz_v),
        .stage_t  (hz_t),
        .stall    (hz_stall)
    );

    assign wr_en  = l_v;
    assign wr_idx = l_tgt;

endmodule

// File: rtl/fpdc_checker.sv
// Module: assertion checker for the deferred commit pipeline.
// Observes the top-level ports only and is attached with bind below.
module fpdc_checker #(
    parameter int IDX_W  = 3,
    parameter int STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_tgt,
    input logic             rd_valid,
    input logic [IDX_W-1:0] rd_idx,
    input logic             hz_stall,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx
);

    // R1: quiet outputs in the first clock after reset.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!wr_en && !hz_stall));

    // R6, R7: a reader of the register being written this clock stalls.
    a_r6_write_hit_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && wr_en && (rd_idx == wr_idx)) |-> hz_stall);

    if (STAGES == 2) begin : g_two
        // R3: the write appears two clocks after issue, with the issued target.
        a_r3_commit_two: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid |=> ##1 (wr_en && (wr_idx == $past(iss_tgt, 2))));

        // R5: no issue means no write two clocks later.
        a_r5_idle_two: assert property (@(posedge clk) disable iff (!rst_n)
            !iss_valid |=> ##1 !wr_en);

        // R7: a reader of the target captured at the last edge stalls.
        a_r7_stage0_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && $past(rst_n) && $past(iss_valid)
             && (rd_idx == $past(iss_tgt))) |-> hz_stall);
    end else begin : g_one
        // R2: the write appears one clock after issue.
        a_r2_commit_one: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid |=> (wr_en && (wr_idx == $past(iss_tgt))));

        // R5: no issue means no write on the next clock.
        a_r5_idle_one: assert property (@(posedge clk) disable iff (!rst_n)
            !iss_valid |=> !wr_en);
    end

endmodule

bind fp_defer_commit fpdc_checker #(
    .IDX_W  (IDX_W),
    .STAGES (STAGES)
) u_fpdc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_tgt   (iss_tgt),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx),
    .hz_stall  (hz_stall),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx)
);

// File: tb/test_fp_defer_commit.sv
// Bench: runs a one-stage and a two-stage instance on the same stream
// and compares both against a behavioural queue model on every clock.
module test_fp_defer_commit;

    localparam int W  = 16;
    localparam int F  = 8;
    localparam int IW = 3;
    localparam int NR = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          iss_valid = 1'b0;
    logic [1:0]    iss_op = '0;
    logic [W-1:0]  iss_a = '0;
    logic [W-1:0]  iss_b = '0;
    logic [IW-1:0] iss_tgt = '0;
    logic          rd_valid = 1'b0;
    logic [IW-1:0] rd_idx = '0;

    logic          st1, we1, st2, we2;
    logic [IW-1:0] wi1, wi2;
    logic [W-1:0]  wd1, wd2;

    fp_defer_commit #(.DATA_W(W), .FRAC_W(F), .IDX_W(IW), .STAGES(2)) i_fp_defer_commit (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a(iss_a), .iss_b(iss_b), .iss_tgt(iss_tgt), .rd_valid(rd_valid),
        .rd_idx(rd_idx), .hz_stall(st2), .wr_en(we2), .wr_idx(wi2), .wr_data(wd2));

    fp_defer_commit #(.DATA_W(W), .FRAC_W(F), .IDX_W(IW), .STAGES(1)) i_fp_defer_commit_s1 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a(iss_a), .iss_b(iss_b), .iss_tgt(iss_tgt), .rd_valid(rd_valid),
        .rd_idx(rd_idx), .hz_stall(st1), .wr_en(we1), .wr_idx(wi1), .wr_data(wd1));

    typedef struct {
        bit v;
        int idx;
        int data;
        int op;
        int cyc;
    } ent_t;

    ent_t q1[$];
    ent_t q2[$];
    int   mrf1[NR];
    int   mrf2[NR];
    int   drf1[NR];
    int   drf2[NR];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   n_iss = 0;
    int   n_wr1 = 0;
    int   n_wr2 = 0;
    bit   done = 1'b0;

    function automatic int ref_eval(int op, int a, int b);
        longint r;
        longint hi = (longint'(1) <<< (W - 1)) - 1;
        case (op)
            0:       r = longint'(a) + longint'(b);
            1:       r = longint'(a) - longint'(b);
            2:       r = (longint'(a) * longint'(b) + (longint'(1) <<< (F - 1))) >>> F;
            default: r = longint'(a) * longint'(b);
        endcase
        if (r > hi) r = hi;
        if (r < -hi - 1) r = -hi - 1;
        return int'(r);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic check_dut(input int d, input ent_t e, input bit hz_exp,
                             input logic we, input logic [IW-1:0] wi,
                             input logic [W-1:0] wd, input logic st, input bit first);
        string t_en;
        string t_hz;
        if (first) begin
            t_en = "R1 wr_en after reset";
            t_hz = "R1 stall after reset";
        end else begin
            t_en = e.v ? ((d == 1) ? "R2 write at N+1" : "R3 write at N+2")
                       : "R5 no write without issue";
            t_hz = (d == 1) ? "R6 hazard one-stage" : "R7 hazard two-stage";
        end
        chk(t_en, int'(we), int'(e.v));
        chk(t_hz, int'(st), int'(hz_exp));
        if (e.v && we) begin
            chk((d == 1) ? "R2 write index" : "R3 write index", int'(wi), e.idx);
            chk((e.op < 2) ? "R8 add/sub data" : "R9 multiply data",
                int'($signed(wd)), e.data);
            chk("R11 commit by issue+3", ((cyc - e.cyc) <= 3) ? 1 : 0, 1);
        end
    endtask

    task automatic step(input bit iv, input int op, input int a, input int b,
                        input int tgt, input bit rv, input int ridx, input bit first = 1'b0);
        ent_t e;
        bit   hz1;
        bit   hz2;
        @(negedge clk);
        cyc++;
        iss_valid = iv;
        iss_op    = op[1:0];
        iss_a     = a[W-1:0];
        iss_b     = b[W-1:0];
        iss_tgt   = tgt[IW-1:0];
        rd_valid  = rv;
        rd_idx    = ridx[IW-1:0];
        #1;
        hz1 = 1'b0;
        hz2 = 1'b0;
        foreach (q1[i]) if (rv && q1[i].v && q1[i].idx == ridx) hz1 = 1'b1;
        foreach (q2[i]) if (rv && q2[i].v && q2[i].idx == ridx) hz2 = 1'b1;
        check_dut(1, q1[0], hz1, we1, wi1, wd1, st1, first);
        check_dut(2, q2[0], hz2, we2, wi2, wd2, st2, first);
        if (we1) begin drf1[wi1] = int'($signed(wd1)); n_wr1++; end
        if (we2) begin drf2[wi2] = int'($signed(wd2)); n_wr2++; end
        if (q1[0].v) mrf1[q1[0].idx] = q1[0].data;
        if (q2[0].v) mrf2[q2[0].idx] = q2[0].data;
        void'(q1.pop_front());
        void'(q2.pop_front());
        e.v    = iv;
        e.idx  = iv ? tgt : 0;
        e.op   = op;
        e.data = iv ? ref_eval(op, a, b) : 0;
        e.cyc  = cyc;
        if (iv) n_iss++;
        q1.push_back(e);
        q2.push_back(e);
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(0, (1 << W) - 1)) - (1 << (W - 1));
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus: reset, directed timing and hazard cases, corner arithmetic,
    // a back-to-back burst, a sparse random stream, and the final state compare.
    initial begin
        ent_t z;
        z.v = 1'b0; z.idx = 0; z.data = 0; z.op = 0; z.cyc = 0;
        q1.push_back(z);
        q2.push_back(z);
        q2.push_back(z);
        for (int i = 0; i < NR; i++) begin
            mrf1[i] = 0; mrf2[i] = 0; drf1[i] = 0; drf2[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 1, 0, 1'b1);            // R1

        // R2 R3 R6 R7: a single add into register 3, then probe it as it drains.
        step(1, 0, 100, 23, 3, 0, 0);
        step(0, 0, 0, 0, 0, 1, 3);                  // in stage 0 for both depths
        step(0, 0, 0, 0, 0, 1, 3);                  // only the two-stage form still holds it
        step(0, 0, 0, 0, 0, 1, 3);                  // drained: no stall
        step(1, 1, 7, 9, 6, 1, 2);                  // probe of an unrelated index
        step(0, 0, 0, 0, 0, 0, 6);                  // rd_valid low: no stall

        // R8 R9: saturation and rounding corners.
        step(1, 0, 32767, 1, 1, 0, 0);
        step(1, 1, -32768, 1, 2, 1, 1);
        step(1, 2, 3, 128, 4, 1, 2);
        step(1, 2, -3, 128, 5, 1, 4);
        step(1, 2, -32768, -32768, 6, 0, 0);
        step(1, 3, 300, 300, 7, 0, 0);
        step(1, 3, -300, 300, 0, 1, 7);
        step(1, 2, 1, 127, 3, 0, 0);
        step(1, 2, -1, 128, 2, 0, 0);
        repeat (3) step(0, 0, 0, 0, 0, 0, 0);

        // R4: back-to-back issue every clock.
        for (int i = 0; i < 150; i++) begin
            step(1, int'($urandom_range(0, 3)), rnd_s(), rnd_s(),
                 int'($urandom_range(0, NR - 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, NR - 1)));
        end

        // Sparse random stream with gaps.
        for (int i = 0; i < 300; i++) begin
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), rnd_s(), rnd_s(),
                 int'($urandom_range(0, NR - 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, NR - 1)));
        end
        repeat (4) step(0, 0, 0, 0, 0, 0, 0);

        chk("R4 writes equal issues one-stage", n_wr1, n_iss);
        chk("R4 writes equal issues two-stage", n_wr2, n_iss);
        for (int i = 0; i < NR; i++) begin
            chk("R10 final register match between depths", drf2[i], drf1[i]);
            chk("R10 final register match two-stage vs model", drf2[i], mrf2[i]);
            chk("R10 final register match one-stage vs model", drf1[i], mrf1[i]);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule